// File: doc/BRIEF.md
# I2C Register-File Target with Strapped Address

This block is a synchronous I2C target. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an open-drain enable: when `sda_oe` is 1 the pad pulls SDA low, and when it is 0 the pad releases the line. The block finds start, repeated-start and stop conditions. It compares each address byte with a 7-bit address made of a fixed 4-bit parameter prefix and three strap pins. On a match it acknowledges and moves data bytes into or out of a small internal register file.

In a write frame, the first data byte after the address loads a register pointer. Every later byte is stored at the pointer, and the pointer then advances. A read frame returns bytes starting at the current pointer. The pointer keeps its value across frames, so a common sequence is a pointer write, then a repeated start, then a read.

A build option turns the block into bank mode. In bank mode the three address bits below the prefix no longer compare against the straps. Instead they pick one of eight register banks.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and every register in the file reads back as 8'h00.
- R2: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start in any state, including partway through an address byte, begins a new address byte. A stop releases SDA and returns the block to idle.
- R3: The address byte arrives MSB first. Bits [7:4] must equal the parameter `PREFIX`, bits [3:1] must equal `strap_i`, and bit [0] gives the direction (0 means the controller writes, 1 means the controller reads). On a match the target holds SDA low for the whole of the 9th clock.
- R4: When the address does not match, the target does not acknowledge. It leaves SDA released for the rest of the frame, up to the next start or stop.
- R5: In a write frame, the target acknowledges every data byte with SDA low during the 9th clock. The first data byte sets the register pointer to its low bits.
- R6: Each later write byte is stored at the pointer, and the pointer then increments. After register REG_DEPTH-1 the pointer wraps to 0.
- R7: In a read frame, the target sends the register at the pointer, MSB first, with each bit changed only while SCL is low. It advances the pointer once per byte sent, with the same wrap as in R6.
- R8: In a read, if the controller leaves SDA high in the 9th clock (a not-acknowledge), data transmission ends. The target keeps SDA released until the next start or stop.
- R9: With `BANK_MODE` set, address bits [3:1] select one of eight separate banks of REG_DEPTH registers, and the target accepts any value of `strap_i`. One pointer is shared by all banks.
- R10: `sda_oe` changes only in cycles where the synchronized SCL was low on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| strap_i | input | 3 | Address strap pins, compared with address bits [3:1] in strap mode |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A wrong internal state shows up at the pins within one byte time. Examples are a bit counter off by one, a missed start, or a pointer that failed to load or advance. The acknowledge then falls in the wrong clock or never appears, or the data read back differs from the bench's register model on the next read frame. Two targets share one bus in the bench: one in strap mode and one in bank mode. A target that drives SDA when it should stay silent therefore corrupts bits that the other target or the controller expects to see high. The pointer wrap and the bank separation only show through later reads, so every write is followed by reads from the affected registers. These reads start just below the wrap point.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the I2C target: protocol states and the bus event bundle.
package i2c_tgt_pkg;

    typedef enum logic [3:0] {
        T_IDLE,      // waiting for a start condition
        T_ADDR,      // shifting in the address byte
        T_ADDR_END,  // address complete, waiting for SCL low to answer
        T_ADDR_ACK,  // holding the address acknowledge
        T_WR,        // shifting in a write data byte
        T_WR_END,    // write byte complete, waiting for SCL low
        T_WR_ACK,    // holding the write acknowledge
        T_RD,        // sending a read data byte
        T_RD_ACK,    // released, sampling the controller acknowledge
        T_RD_NEXT,   // acknowledged, load next byte on SCL low
        T_SKIP       // not addressed or read ended; silent until start/stop
    } tgt_state_e;

    typedef struct packed {
        logic scl;       // synchronized SCL level
        logic sda;       // synchronized SDA level
        logic scl_rise;  // one-cycle pulse on SCL rising
        logic scl_fall;  // one-cycle pulse on SCL falling
        logic start;     // start or repeated start seen
        logic stop;      // stop seen
    } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Synchronizes the SCL and SDA pad inputs into the system clock domain and
// derives edge and bus-condition pulses.
// Assumes: STAGES >= 2, and the system clock is fast enough that each SCL
// phase lasts several clocks. An idle bus is high, so the flops reset to 1.
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    // Synchronizer chains plus one history flop per line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_now = scl_ff[STAGES-1];
    assign sda_now = sda_ff[STAGES-1];

    // Edge pulses and start/stop decode from current and previous levels.
    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_d;
        ev.scl_fall = ~scl_now & scl_d;
        ev.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop     = scl_now & scl_d & ~sda_d & sda_now;
    end

endmodule

// File: rtl/i2c_tgt_regfile.sv
// Byte-wide register file with one shared index, synchronous write and
// combinational read, so a byte can be loaded in the same cycle it is needed.
// Assumes: WORDS = 2**IDX_W entries. All entries clear on reset.
module i2c_tgt_regfile #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    // Storage: clear on reset, write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Protocol engine of the I2C target. It shifts in address and data bits on SCL
// rising edges, decides on address matches, acknowledges, streams read data
// MSB first, and keeps the register pointer (and, in bank mode, the bank).
// Assumes: bus events come from i2c_tgt_sync. SDA is only changed on an SCL
// falling event, and start/stop take priority over all other activity.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] PREFIX    = 4'b1010,
    parameter bit         BANK_MODE = 1'b0,
    parameter int         REG_DEPTH = 8,
    parameter int         PTR_W     = $clog2(REG_DEPTH),
    parameter int         BANK_W    = 3,
    parameter int         IDX_W     = PTR_W + (BANK_MODE ? BANK_W : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap_i,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [7:0]        mem_wdata,
    output logic              sda_oe,
    output tgt_state_e        state_o
);

    localparam logic [3:0]       LAST_RX  = 4'd7;
    localparam logic [3:0]       LAST_TX  = 4'd8;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_DEPTH - 1);

    tgt_state_e       state_q;
    logic [3:0]       cnt_q;
    logic [6:0]       shift_q;
    logic [6:0]       tx_q;
    logic             oe_q;
    logic             match_q;
    logic             rw_q;
    logic             first_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_next;
    logic [7:0]       byte_in;
    logic             addr_hit;
    logic             addr_done;

    assign byte_in   = {shift_q, ev.sda};
    assign ptr_next  = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    assign addr_hit  = (byte_in[7:4] == PREFIX) &&
                       (BANK_MODE || (byte_in[3:1] == strap_i));
    assign addr_done = (state_q == T_ADDR) && ev.scl_rise && (cnt_q == LAST_RX);

    // Bank selection variant: latch the address field or use a flat index.
    generate
        if (BANK_MODE) begin : g_bank
            logic [BANK_W-1:0] bank_q;

            // Bank register: captured from every completed address byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q <= '0;
                end else if (!ev.start && !ev.stop && addr_done) begin
                    bank_q <= byte_in[3:1];
                end
            end

            assign mem_idx = {bank_q, ptr_q};
        end else begin : g_flat
            assign mem_idx = ptr_q;
        end
    endgenerate

    // Write strobe: the last bit of a non-pointer write byte stores the byte.
    always_comb begin
        mem_we    = (state_q == T_WR) && ev.scl_rise && (cnt_q == LAST_RX) &&
                    !first_q && !ev.start && !ev.stop;
        mem_wdata = byte_in;
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            tx_q    <= '0;
            oe_q    <= 1'b0;
            match_q <= 1'b0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            ptr_q   <= '0;
        end else if (ev.start) begin
            state_q <= T_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (ev.stop) begin
            state_q <= T_IDLE;
            oe_q    <= 1'b0;
        end else begin
            if (ev.scl_rise) begin
                shift_q <= byte_in[6:0];
            end
            unique case (state_q)
                T_ADDR: begin
                    if (ev.scl_rise) begin
                        if (cnt_q == LAST_RX) begin
                            cnt_q   <= '0;
                            match_q <= addr_hit;
                            rw_q    <= byte_in[0];
                            state_q <= T_ADDR_END;
                        end else begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                end
                T_ADDR_END: begin
                    if (ev.scl_fall) begin
                        if (match_q) begin
                            oe_q    <= 1'b1;
                            state_q <= T_ADDR_ACK;
                        end else begin
                            state_q <= T_SKIP;
                        end
                    end
                end
                T_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            tx_q    <= mem_rdata[6:0];
                            oe_q    <= ~mem_rdata[7];
                            ptr_q   <= ptr_next;
                            state_q <= T_RD;
                        end else begin
                            oe_q    <= 1'b0;
                            first_q <= 1'b1;
                            state_q <= T_WR;
                        end
                    end
                end
                T_WR: begin
                    if (ev.scl_rise) begin
                        if (cnt_q == LAST_RX) begin
                            cnt_q   <= '0;
                            state_q <= T_WR_END;
                            if (first_q) begin
                                ptr_q   <= byte_in[PTR_W-1:0];
                                first_q <= 1'b0;
                            end else begin
                                ptr_q <= ptr_next;
                            end
                        end else begin
                            cnt_q <= cnt_q + 4'd1;
                        end
                    end
                end
                T_WR_END: begin
                    if (ev.scl_fall) begin
                        oe_q    <= 1'b1;
                        state_q <= T_WR_ACK;
                    end
                end
                T_WR_ACK: begin
                    if (ev.scl_fall) begin
                        oe_q    <= 1'b0;
                        state_q <= T_WR;
                    end
                end
                T_RD: begin
                    if (ev.scl_rise) begin
                        cnt_q <= cnt_q + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (cnt_q == LAST_TX) begin
                            oe_q    <= 1'b0;
                            state_q <= T_RD_ACK;
                        end else begin
                            tx_q <= {tx_q[5:0], 1'b0};
                            oe_q <= ~tx_q[6];
                        end
                    end
                end
                T_RD_ACK: begin
                    if (ev.scl_rise) begin
                        state_q <= ev.sda ? T_SKIP : T_RD_NEXT;
                    end
                end
                T_RD_NEXT: begin
                    if (ev.scl_fall) begin
                        cnt_q   <= '0;
                        tx_q    <= mem_rdata[6:0];
                        oe_q    <= ~mem_rdata[7];
                        ptr_q   <= ptr_next;
                        state_q <= T_RD;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign sda_oe  = oe_q;
    assign state_o = state_q;

endmodule

// File: rtl/i2c_strap_target.sv
// Top of the I2C target. It joins the input synchronizer, the protocol engine
// and the register file.
// Assumes: an external open-drain pad pulls SDA low while sda_oe is 1. In
// bank mode strap_i is ignored. REG_DEPTH is a power of two.
module i2c_strap_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] PREFIX      = 4'b1010,
    parameter bit         BANK_MODE   = 1'b0,
    parameter int         REG_DEPTH   = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe
);

    localparam int PTR_W  = $clog2(REG_DEPTH);
    localparam int BANK_W = 3;
    localparam int IDX_W  = PTR_W + (BANK_MODE ? BANK_W : 0);

    bus_ev_t          bus_ev;
    tgt_state_e       fsm_state;
    logic             mem_we;
    logic [IDX_W-1:0] mem_idx;
    logic [7:0]       mem_wdata;
    logic [7:0]       mem_rdata;
    logic             scl_sync;
    logic             start_seen;
    logic             stop_seen;

    i2c_tgt_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    i2c_tgt_fsm #(
        .PREFIX    (PREFIX),
        .BANK_MODE (BANK_MODE),
        .REG_DEPTH (REG_DEPTH),
        .PTR_W     (PTR_W),
        .BANK_W    (BANK_W),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (bus_ev),
        .strap_i   (strap_i),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe),
        .state_o   (fsm_state)
    );

    i2c_tgt_regfile #(
        .IDX_W  (IDX_W),
        .DATA_W (8)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign scl_sync   = bus_ev.scl;
    assign start_seen = bus_ev.start;
    assign stop_seen  = bus_ev.stop;

endmodule

// File: rtl/i2c_tgt_chk.sv
// Protocol checker for i2c_strap_target, attached to every instance by bind.
// Assumes: synchronous active-low reset. All properties are disabled in reset.
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_sync,
    input logic       start_seen,
    input logic       stop_seen,
    input tgt_state_e state,
    input logic       mem_we
);

    AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe); // R1

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (state == T_ADDR) && !sda_oe); // R2

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (state == T_IDLE) && !sda_oe); // R2

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_SKIP) |-> !sda_oe); // R4

    AST_WRITE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !sda_oe); // R5

    AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_RD_ACK) |-> !sda_oe); // R8

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_sync)); // R10

endmodule

bind i2c_strap_target i2c_tgt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe),
    .scl_sync   (scl_sync),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .state      (fsm_state),
    .mem_we     (mem_we)
);

// File: tb/i2c_strap_target_tb_top.sv
`timescale 1ns/1ps
module i2c_strap_target_tb_top;

    localparam int         Q       = 6;
    localparam logic [2:0] STRAP_A = 3'b101;
    localparam logic [3:0] PFX_A   = 4'hA;
    localparam logic [3:0] PFX_B   = 4'h5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c_scl = 1'b1;
    logic c_sda = 1'b1;
    logic oe_a;
    logic oe_b;
    wire  sda_bus = c_sda & ~oe_a & ~oe_b;

    int checks = 0;
    int errors = 0;

    logic [7:0] model_a [8];
    logic [7:0] model_b [8][8];
    int         ptr_m [2];

    always #4 clk = ~clk;

    i2c_strap_target #(.PREFIX(PFX_A), .BANK_MODE(1'b0), .REG_DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(c_scl), .sda_i(sda_bus),
        .strap_i(STRAP_A), .sda_oe(oe_a));

    i2c_strap_target #(.PREFIX(PFX_B), .BANK_MODE(1'b1), .REG_DEPTH(8)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .scl_i(c_scl), .sda_i(sda_bus),
        .strap_i(3'b000), .sda_oe(oe_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_of(input int tgt, input int bank, input bit rw);
        if (tgt == 0) return {PFX_A, STRAP_A, rw};
        return {PFX_B, 3'(bank), rw};
    endfunction

    function automatic logic [7:0] mget(input int tgt, input int bank, input int idx);
        if (tgt == 0) return model_a[idx];
        return model_b[bank][idx];
    endfunction

    function automatic void mset(input int tgt, input int bank, input int idx, input logic [7:0] v);
        if (tgt == 0) model_a[idx] = v;
        else model_b[bank][idx] = v;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        c_sda = 1'b1; wq(); c_scl = 1'b1; wq(); c_sda = 1'b0; wq(); c_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        c_sda = 1'b0; wq(); c_scl = 1'b1; wq(); c_sda = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input bit b);
        c_sda = b; wq(); c_scl = 1'b1; wq(); wq(); c_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output bit b);
        c_sda = 1'b1; wq(); c_scl = 1'b1; wq(); b = sda_bus; wq(); c_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(output logic [7:0] v, input bit nack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    // Write frame: address, pointer byte, then n data bytes (R3, R5, R6).
    task automatic xfer_write(input int tgt, input int bank, input int ra, input int n,
                              input logic [31:0] dat);
        bit ack;
        bus_start();
        put_byte(addr_of(tgt, bank, 1'b0), ack);
        chk(ack == 1'b0, "R3 address ack", ack, 0);
        put_byte(8'(ra), ack);
        chk(ack == 1'b0, "R5 pointer ack", ack, 0);
        ptr_m[tgt] = ra;
        for (int k = 0; k < n; k++) begin
            put_byte(dat[8*k +: 8], ack);
            chk(ack == 1'b0, "R6 data ack", ack, 0);
            mset(tgt, bank, ptr_m[tgt], dat[8*k +: 8]);
            ptr_m[tgt] = (ptr_m[tgt] + 1) % 8;
        end
        bus_stop();
        chk(!oe_a && !oe_b, "R2 released after stop", {oe_a, oe_b}, 0);
    endtask

    // Read frame, optionally preceded by a pointer write and repeated start (R7, R8).
    task automatic xfer_read(input int tgt, input int bank, input int ra, input int n);
        bit ack;
        bit extra;
        logic [7:0] v;
        logic [7:0] e;
        bus_start();
        if (ra >= 0) begin
            put_byte(addr_of(tgt, bank, 1'b0), ack);
            chk(ack == 1'b0, "R3 address ack", ack, 0);
            put_byte(8'(ra), ack);
            chk(ack == 1'b0, "R5 pointer ack", ack, 0);
            ptr_m[tgt] = ra;
            bus_start();
        end
        put_byte(addr_of(tgt, bank, 1'b1), ack);
        chk(ack == 1'b0, "R3 read address ack", ack, 0);
        for (int k = 0; k < n; k++) begin
            get_byte(v, k == n - 1);
            e = mget(tgt, bank, ptr_m[tgt]);
            chk(v == e, (tgt == 0) ? "R7 read data" : "R9 bank read data", v, e);
            ptr_m[tgt] = (ptr_m[tgt] + 1) % 8;
        end
        chk(!oe_a && !oe_b, "R8 released after nack", {oe_a, oe_b}, 0);
        get_bit(extra);
        chk(extra == 1'b1, "R8 silent after nack", extra, 1);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 190000 cycles expected completion earlier");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit ack;
        logic [7:0] v;
        int unsigned seed_dummy;
        for (int i = 0; i < 8; i++) begin
            model_a[i] = 8'h00;
            for (int j = 0; j < 8; j++) model_b[i][j] = 8'h00;
        end
        ptr_m[0] = 0;
        ptr_m[1] = 0;
        seed_dummy = $urandom(32'd20240611);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!oe_a && !oe_b, "R1 reset release", {oe_a, oe_b}, 0);
        xfer_read(0, 0, 0, 8);   // R1: all registers of strap-mode target zero
        xfer_read(1, 6, 0, 8);   // R1: bank 6 of bank-mode target zero

        // R4: wrong strap value, no ack, bus stays high through a byte
        bus_start();
        put_byte({PFX_A, 3'b010, 1'b0}, ack);
        chk(ack == 1'b1, "R4 no ack on strap mismatch", ack, 1);
        get_byte(v, 1'b1);
        chk(v == 8'hFF, "R4 bus untouched", v, 8'hFF);
        bus_stop();
        bus_start();
        put_byte({PFX_A, 3'b011, 1'b1}, ack);
        chk(ack == 1'b1, "R4 no ack on read mismatch", ack, 1);
        get_byte(v, 1'b1);
        chk(v == 8'hFF, "R4 no read data driven", v, 8'hFF);
        bus_stop();

        // R2: repeated start in the middle of an address byte
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        put_byte(addr_of(0, 0, 1'b0), ack);
        chk(ack == 1'b0, "R2 ack after mid-byte repeated start", ack, 0);
        put_byte(8'd3, ack);
        chk(ack == 1'b0, "R5 pointer ack", ack, 0);
        put_byte(8'h5A, ack);
        chk(ack == 1'b0, "R5 data ack", ack, 0);
        model_a[3] = 8'h5A;
        ptr_m[0] = 4;
        bus_stop();
        xfer_read(0, 0, 3, 1);

        // R6/R7: write and read across the wrap point
        xfer_write(0, 0, 7, 2, 32'h0000_B311);
        xfer_read(0, 0, 6, 3);

        // R5: pointer-only write, then read without a pointer byte
        xfer_write(0, 0, 3, 0, 32'h0);
        xfer_read(0, 0, -1, 2);

        // R9: banks are separate and strap pins are ignored
        xfer_write(1, 3, 2, 1, 32'h0000_00C3);
        xfer_read(1, 3, 2, 1);
        xfer_read(1, 5, 2, 1);
        xfer_read(0, 0, 2, 1);

        // Constrained random traffic on both targets
        for (int it = 0; it < 36; it++) begin
            int tgt;
            int bank;
            int ra;
            int n;
            logic [31:0] dat;
            tgt  = int'($urandom % 2);
            bank = int'($urandom % 8);
            ra   = int'($urandom % 8);
            n    = 1 + int'($urandom % 4);
            dat  = $urandom;
            if ($urandom % 2 == 0) xfer_write(tgt, bank, ra, n, dat);
            else xfer_read(tgt, bank, (($urandom % 4) == 0) ? -1 : ra, n);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule